// File: doc/BRIEF.md
# Boot-Block Flash Command Interface and Write Sequencer

This block is the command front end of a five-block flash memory: one boot block, two parameter blocks and two main blocks, with the boot block at the top or the bottom of the word address map. A host writes one-cycle and two-cycle commands through an SRAM-like strobe interface. Address and data are taken on the rising edge of the write strobe while chip-enable is low. An internal sequencer then programs a word or erases a whole block in a behavioural array. Each operation takes a fixed number of clock cycles.

A reset input shuts the whole block down while it is low. It also has a high-voltage level, which arrives here as the flag `hv_unlock` and is the only way to alter the boot block. A second flag, `vpp_ok`, stands for the program supply. Without it, program and erase never run. A status word reports readiness, suspension and error causes. A running erase can be paused so that the array can be read, and then resumed.

The array uses units of 2^UNIT_AW words. There are 32 units, and unit index = address >> UNIT_AW. In the bottom-boot map the units are laid out as follows:
- units 0–1: boot block
- unit 2: parameter block A
- unit 3: parameter block B
- units 4–15: 96K main block
- units 16–31: 128K main block

The top-boot map is the mirror image, using unit 31 − u.

Top module: `bootflash_cui`

## Requirements
- R1: A write is taken only on a rising edge of `we_n` while `ce_n` is low. A strobe with `ce_n` high changes neither the array nor the read mode. `rdata` is zero while `ce_n` is high.
- R2: While `pwr_rst_n` is low, any running operation is abandoned, the status error bits are cleared and writes are ignored. The block comes out of reset in read-array mode, with array contents retained.
- R3: Program is command 0x40 followed by a data write at the target address. Exactly PROG_CYC cycles after the data write, the word holds old AND new data. Status bit 7 (ready) is 0 for those PROG_CYC cycles.
- R4: Erase is command 0x20 followed by 0xD0, addressed anywhere in a block. After ERASE_CYC busy cycles, every word of that block reads all ones and other blocks are unchanged.
- R5: An erase setup followed by anything other than 0xD0 sets status bits 5 and 4 and erases nothing.
- R6: With `vpp_ok` low, a program attempt sets bits 4 and 3, and an erase attempt sets bits 5 and 3. The array is not altered. Commands 0xFF, 0x70, 0x50 and 0x90 still act.
- R7: With `hv_unlock` low, a program or erase aimed at the boot block sets bit 4 (program) or bit 5 (erase) and does not alter it. With `hv_unlock` high the operation runs. Parameter and main blocks are never locked.
- R8: Parameter BOOT_TOP=1 mirrors the block map, so the boot block occupies units 30–31.
- R9: Status is read as {ready, suspended, erase error, program error, supply low} in bits 7..3, with other bits zero. 0x70 selects the status view, and 0xFF selects the array view. 0x50 clears bits 5..3. Error bits change only on an accepted write.
- R10: 0xB0 during an erase stops its cycle count and shows status 0xC0. The array can be read in this state. A following 0xD0 resumes the erase, which then completes.
- R11: 0x90 selects the identifier view. Address bit 0 low reads the maker code 0x5A. Address bit 0 high reads the device code, 0xC4 for bottom boot and 0xC3 for top boot.
- R12: While the sequencer is busy, reads return status. Writes other than 0x70 and 0xB0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_rst_n | input | 1 | Reset input at logic level, active low |
| hv_unlock | input | 1 | Reset input is at the high-voltage level, so the boot block may be altered |
| vpp_ok | input | 1 | Program supply present |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; its rising edge takes the write |
| addr | input | AW | Word address |
| wdata | input | DW | Command or program data |
| rdata | output | DW | Array, status or identifier word |

## Verification
The inline assertions check, on every cycle, four rules. No operation starts while the sequencer is busy or suspended. No start happens without the supply flag, or against the boot block without unlock. A suspended erase holds its cycle count. The error bits move only on an accepted write. The bench scenarios are the only evidence for the rest: the AND result of programming, which words an erase reaches, exact busy lengths, the mirrored map, identifier codes, and state surviving a reset pulse.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

   localparam int UNIT_BITS = 5;

   typedef enum logic [2:0] {BLK_BOOT, BLK_PARA, BLK_PARB, BLK_MAIN96, BLK_MAIN128} blk_e;
   typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_ERASE} op_e;
   typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT} rdmode_e;
   typedef enum logic [1:0] {CS_IDLE, CS_PSETUP, CS_ESETUP} cstate_e;

   localparam logic [7:0] CMD_READ  = 8'hFF;
   localparam logic [7:0] CMD_STAT  = 8'h70;
   localparam logic [7:0] CMD_CLR   = 8'h50;
   localparam logic [7:0] CMD_IDENT = 8'h90;
   localparam logic [7:0] CMD_PROG  = 8'h40;
   localparam logic [7:0] CMD_ERASE = 8'h20;
   localparam logic [7:0] CMD_CONF  = 8'hD0;
   localparam logic [7:0] CMD_SUSP  = 8'hB0;

   // bottom-boot layout, in units
   function automatic blk_e unit_to_blk(input logic [UNIT_BITS-1:0] u);
      if (u < 5'd2)       return BLK_BOOT;
      else if (u == 5'd2) return BLK_PARA;
      else if (u == 5'd3) return BLK_PARB;
      else if (u < 5'd16) return BLK_MAIN96;
      else                return BLK_MAIN128;
   endfunction

   function automatic logic [UNIT_BITS-1:0] blk_first(input blk_e b);
      case (b)
         BLK_BOOT:   return 5'd0;
         BLK_PARA:   return 5'd2;
         BLK_PARB:   return 5'd3;
         BLK_MAIN96: return 5'd4;
         default:    return 5'd16;
      endcase
   endfunction

   function automatic logic [UNIT_BITS-1:0] blk_last(input blk_e b);
      case (b)
         BLK_BOOT:   return 5'd1;
         BLK_PARA:   return 5'd2;
         BLK_PARB:   return 5'd3;
         BLK_MAIN96: return 5'd15;
         default:    return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/bbf_blkmap.sv
module bbf_blkmap
   import bbf_pkg::*;
#(
   parameter int UNIT_AW  = 2,
   parameter bit BOOT_TOP = 1'b0,
   parameter int AW       = UNIT_AW + UNIT_BITS
)(
   input  logic [AW-1:0]        addr_i,
   output blk_e                 blk_o,
   output logic [UNIT_BITS-1:0] first_o,
   output logic [UNIT_BITS-1:0] last_o
);

   logic [UNIT_BITS-1:0] unit_raw;
   assign unit_raw = addr_i[AW-1 -: UNIT_BITS];

   generate
      if (BOOT_TOP) begin : g_top
         always_comb begin
            blk_o   = unit_to_blk(~unit_raw);
            first_o = ~blk_last(blk_o);
            last_o  = ~blk_first(blk_o);
         end
      end else begin : g_bottom
         always_comb begin
            blk_o   = unit_to_blk(unit_raw);
            first_o = blk_first(blk_o);
            last_o  = blk_last(blk_o);
         end
      end
   endgenerate

endmodule

// File: rtl/bbf_cmd.sv
module bbf_cmd
   import bbf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb_i,
   input  logic [7:0] cmd_i,
   input  logic       locked_i,
   input  logic       vpp_i,
   input  logic       busy_i,
   input  logic       susp_i,
   input  logic       erasing_i,
   output logic       start_prog_o,
   output logic       start_erase_o,
   output logic       susp_req_o,
   output logic       resume_req_o,
   output rdmode_e    rdm_o,
   output logic [2:0] err_o
);

   cstate_e cst_q;
   rdmode_e rdm_q;
   logic    eerr_q, perr_q, vlow_q;
   logic    idle_stb;

   assign idle_stb      = stb_i && !busy_i;
   assign start_prog_o  = idle_stb && (cst_q == CS_PSETUP) && vpp_i && !locked_i;
   assign start_erase_o = idle_stb && (cst_q == CS_ESETUP) && (cmd_i == CMD_CONF)
                          && vpp_i && !locked_i;
   assign susp_req_o    = stb_i && busy_i && erasing_i && (cmd_i == CMD_SUSP);
   assign resume_req_o  = idle_stb && susp_i && (cst_q == CS_IDLE) && (cmd_i == CMD_CONF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cst_q  <= CS_IDLE;
         rdm_q  <= RD_ARRAY;
         eerr_q <= 1'b0;
         perr_q <= 1'b0;
         vlow_q <= 1'b0;
      end else if (stb_i && busy_i) begin
         if (cmd_i == CMD_STAT) rdm_q <= RD_STATUS;
      end else if (idle_stb) begin
         case (cst_q)
            CS_PSETUP: begin
               cst_q <= CS_IDLE;
               rdm_q <= RD_STATUS;
               if (!vpp_i) begin
                  perr_q <= 1'b1;
                  vlow_q <= 1'b1;
               end else if (locked_i) begin
                  perr_q <= 1'b1;
               end
            end
            CS_ESETUP: begin
               cst_q <= CS_IDLE;
               rdm_q <= RD_STATUS;
               if (cmd_i != CMD_CONF) begin
                  eerr_q <= 1'b1;
                  perr_q <= 1'b1;
               end else if (!vpp_i) begin
                  eerr_q <= 1'b1;
                  vlow_q <= 1'b1;
               end else if (locked_i) begin
                  eerr_q <= 1'b1;
               end
            end
            default: begin
               case (cmd_i)
                  CMD_READ:  rdm_q <= RD_ARRAY;
                  CMD_STAT:  rdm_q <= RD_STATUS;
                  CMD_IDENT: rdm_q <= RD_IDENT;
                  CMD_CLR: begin
                     eerr_q <= 1'b0;
                     perr_q <= 1'b0;
                     vlow_q <= 1'b0;
                  end
                  CMD_PROG: if (!susp_i) begin
                     cst_q <= CS_PSETUP;
                     rdm_q <= RD_STATUS;
                  end
                  CMD_ERASE: if (!susp_i) begin
                     cst_q <= CS_ESETUP;
                     rdm_q <= RD_STATUS;
                  end
                  CMD_CONF: if (susp_i) rdm_q <= RD_STATUS;
                  default: ;
               endcase
            end
         endcase
      end
   end

   assign rdm_o = rdm_q;
   assign err_o = {eerr_q, perr_q, vlow_q};

endmodule

// File: rtl/bbf_seq.sv
module bbf_seq
   import bbf_pkg::*;
#(
   parameter int DW        = 16,
   parameter int UNIT_AW   = 2,
   parameter int PROG_CYC  = 4,
   parameter int ERASE_CYC = 12,
   parameter int AW        = UNIT_AW + UNIT_BITS
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_prog_i,
   input  logic                 start_erase_i,
   input  logic                 susp_req_i,
   input  logic                 resume_req_i,
   input  logic [AW-1:0]        addr_i,
   input  logic [DW-1:0]        data_i,
   input  logic [UNIT_BITS-1:0] first_i,
   input  logic [UNIT_BITS-1:0] last_i,
   output logic                 busy_o,
   output logic                 susp_o,
   output logic                 erasing_o,
   output logic [DW-1:0]        rd_word_o
);

   localparam int DEPTH = 1 << AW;
   localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CW    = $clog2(MAXC + 1);

   logic [DW-1:0]        mem [DEPTH];
   op_e                  op_q;
   logic                 busy_q, susp_q;
   logic [CW-1:0]        cnt_q;
   logic [AW-1:0]        a_q;
   logic [DW-1:0]        d_q;
   logic [UNIT_BITS-1:0] first_q, last_q;
   logic                 done_w;
   logic [DEPTH-1:0]     in_blk;

   assign done_w = busy_q && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         busy_q  <= 1'b0;
         susp_q  <= 1'b0;
         cnt_q   <= '0;
         a_q     <= '0;
         d_q     <= '0;
         first_q <= '0;
         last_q  <= '0;
      end else if (start_prog_i) begin
         op_q   <= OP_PROG;
         busy_q <= 1'b1;
         cnt_q  <= CW'(PROG_CYC);
         a_q    <= addr_i;
         d_q    <= data_i;
      end else if (start_erase_i) begin
         op_q    <= OP_ERASE;
         busy_q  <= 1'b1;
         cnt_q   <= CW'(ERASE_CYC);
         first_q <= first_i;
         last_q  <= last_i;
      end else if (susp_req_i) begin
         busy_q <= 1'b0;
         susp_q <= 1'b1;
      end else if (resume_req_i) begin
         busy_q <= 1'b1;
         susp_q <= 1'b0;
      end else if (done_w) begin
         busy_q <= 1'b0;
         op_q   <= OP_NONE;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   // per-word block membership for erase
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_member
      localparam logic [UNIT_BITS-1:0] UNIT = UNIT_BITS'(gi >> UNIT_AW);
      assign in_blk[gi] = (UNIT >= first_q) && (UNIT <= last_q);
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '1;
   end

   always_ff @(posedge clk) begin
      if (done_w && !susp_req_i && op_q == OP_PROG) mem[a_q] <= mem[a_q] & d_q;
      for (int i = 0; i < DEPTH; i++) begin
         if (done_w && !susp_req_i && op_q == OP_ERASE && in_blk[i]) mem[i] <= '1;
      end
   end

   assign busy_o    = busy_q;
   assign susp_o    = susp_q;
   assign erasing_o = (op_q == OP_ERASE);
   assign rd_word_o = mem[addr_i];

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_prog_i || start_erase_i) |-> (!busy_q && !susp_q))
      else $error("operation started while sequencer occupied"); // R12
   AST_SUSP_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> (op_q == OP_ERASE))
      else $error("suspended state without an erase"); // R10
   AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |=> $stable(cnt_q))
      else $error("cycle count moved during suspension"); // R10

endmodule

// File: rtl/bootflash_cui.sv
module bootflash_cui
   import bbf_pkg::*;
#(
   parameter int         DW           = 16,
   parameter int         UNIT_AW      = 2,
   parameter int         PROG_CYC     = 4,
   parameter int         ERASE_CYC    = 12,
   parameter bit         BOOT_TOP     = 1'b0,
   parameter logic [7:0] MFR_CODE     = 8'h5A,
   parameter logic [7:0] DEV_CODE_BOT = 8'hC4,
   parameter logic [7:0] DEV_CODE_TOP = 8'hC3,
   parameter int         AW           = UNIT_AW + UNIT_BITS
)(
   input  logic          clk,
   input  logic          pwr_rst_n,
   input  logic          hv_unlock,
   input  logic          vpp_ok,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   localparam logic [7:0] DEV_CODE = BOOT_TOP ? DEV_CODE_TOP : DEV_CODE_BOT;

   if (DW < 8) begin : g_chk_dw
      $error("DW must hold an 8-bit command");
   end
   if (UNIT_AW < 1) begin : g_chk_unit
      $error("UNIT_AW must be at least 1");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_chk_cyc
      $error("operation lengths must be positive");
   end

   logic                 we_d;
   logic                 wr_stb;
   blk_e                 blk;
   logic [UNIT_BITS-1:0] first_u, last_u;
   logic                 start_prog, start_erase, susp_req, resume_req;
   logic                 busy, susp, erasing;
   rdmode_e              rdm;
   logic [2:0]           err;
   logic [DW-1:0]        arr_word;
   logic [7:0]           stat8;

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) we_d <= 1'b1;
      else            we_d <= we_n;
   end

   assign wr_stb = we_n && !we_d && !ce_n;

   bbf_blkmap #(.UNIT_AW(UNIT_AW), .BOOT_TOP(BOOT_TOP), .AW(AW)) u_map (
      .addr_i (addr),
      .blk_o  (blk),
      .first_o(first_u),
      .last_o (last_u)
   );

   bbf_cmd u_cmd (
      .clk          (clk),
      .rst_n        (pwr_rst_n),
      .stb_i        (wr_stb),
      .cmd_i        (wdata[7:0]),
      .locked_i     ((blk == BLK_BOOT) && !hv_unlock),
      .vpp_i        (vpp_ok),
      .busy_i       (busy),
      .susp_i       (susp),
      .erasing_i    (erasing),
      .start_prog_o (start_prog),
      .start_erase_o(start_erase),
      .susp_req_o   (susp_req),
      .resume_req_o (resume_req),
      .rdm_o        (rdm),
      .err_o        (err)
   );

   bbf_seq #(.DW(DW), .UNIT_AW(UNIT_AW), .PROG_CYC(PROG_CYC),
             .ERASE_CYC(ERASE_CYC), .AW(AW)) u_seq (
      .clk          (clk),
      .rst_n        (pwr_rst_n),
      .start_prog_i (start_prog),
      .start_erase_i(start_erase),
      .susp_req_i   (susp_req),
      .resume_req_i (resume_req),
      .addr_i       (addr),
      .data_i       (wdata),
      .first_i      (first_u),
      .last_i       (last_u),
      .busy_o       (busy),
      .susp_o       (susp),
      .erasing_o    (erasing),
      .rd_word_o    (arr_word)
   );

   assign stat8 = {!busy, susp, err, 3'b000};

   always_comb begin
      if (ce_n)                          rdata = '0;
      else if (busy || rdm == RD_STATUS) rdata = {{(DW-8){1'b0}}, stat8};
      else if (rdm == RD_IDENT)          rdata = {{(DW-8){1'b0}}, addr[0] ? DEV_CODE : MFR_CODE};
      else                               rdata = arr_word;
   end

   AST_SUPPLY_GATE: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (start_prog || start_erase) |-> vpp_ok)
      else $error("alteration started without program supply"); // R6
   AST_BOOT_LOCK: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (start_prog || start_erase) |-> (blk != BLK_BOOT || hv_unlock))
      else $error("locked boot block altered"); // R7
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !wr_stb |=> $stable(err))
      else $error("error bits moved without a write"); // R9

   always @(posedge clk) begin
      if (!pwr_rst_n) begin
         AST_RST_QUIET: assert (!busy && !susp && err == 3'b000)
            else $error("state not cleared under reset"); // R2
      end
   end

endmodule

// File: tb/sim_bootflash_cui.sv
`timescale 1ns/1ps
module sim_bootflash_cui;

   localparam int DW = 16, AW = 7, NP = 4, NE = 12;

   logic          clk = 1'b0;
   logic          rstn = 1'b0, hv = 1'b0, vpp = 1'b1;
   logic          ce0_n = 1'b0, ce1_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] r0, r1;
   int            errors = 0, checks = 0;

   always #5 clk = ~clk;

   bootflash_cui #(.DW(DW), .UNIT_AW(2), .PROG_CYC(NP), .ERASE_CYC(NE), .BOOT_TOP(1'b0)) u0 (
      .clk(clk), .pwr_rst_n(rstn), .hv_unlock(hv), .vpp_ok(vpp),
      .ce_n(ce0_n), .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(r0));

   bootflash_cui #(.DW(DW), .UNIT_AW(2), .PROG_CYC(NP), .ERASE_CYC(NE), .BOOT_TOP(1'b1)) u1 (
      .clk(clk), .pwr_rst_n(rstn), .hv_unlock(hv), .vpp_ok(vpp),
      .ce_n(ce1_n), .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(r1));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // which: 0 selects u0, 1 selects u1, 2 selects neither
   task automatic sel(input int which);
      ce0_n = (which != 0);
      ce1_n = (which != 1);
   endtask

   task automatic wr(input int which, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      sel(which);
      addr = a; wdata = d; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input int which, input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk);
      sel(which);
      addr = a;
      #1;
      v = (which == 1) ? r1 : r0;
   endtask

   task automatic wait_ready(input int which, output int n);
      logic [DW-1:0] v;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         #1;
         v = (which == 1) ? r1 : r0;
         if (v[7]) break;
         n++;
      end
   endtask

   task automatic prog(input int which, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int n;
      wr(which, a, 16'h0040);
      wr(which, a, d);
      wait_ready(which, n);
   endtask

   task automatic erase(input int which, input logic [AW-1:0] a, output int n);
      wr(which, a, 16'h0020);
      wr(which, a, 16'h00D0);
      wait_ready(which, n);
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      rstn = 1'b0;
      wr(0, 7'h15, 16'h0040);
      wr(0, 7'h15, 16'h0000);
      repeat (2) @(negedge clk);
      rstn = 1'b1;
      rd(0, 7'h15, v); chk("R2 read-array after reset", v, 16'hFFFF);
      wr(0, 7'h00, 16'h0070);
      rd(0, 7'h00, v); chk("R9 status after reset", v, 16'h0080);
   endtask

   task automatic t_program;
      logic [DW-1:0] v;
      int n;
      wr(0, 7'h15, 16'h0040);
      wr(0, 7'h15, 16'h1234);
      wait_ready(0, n);
      chk("R3 program busy cycles", 16'(n), 16'(NP));
      wr(0, 7'h15, 16'h00FF);
      rd(0, 7'h15, v); chk("R3 programmed word", v, 16'h1234);
      prog(0, 7'h15, 16'hFF00);
      wr(0, 7'h15, 16'h00FF);
      rd(0, 7'h15, v); chk("R3 program ANDs with stored data", v, 16'h1200);
   endtask

   task automatic t_ce_ignored;
      logic [DW-1:0] v;
      wr(2, 7'h15, 16'h0040);
      wr(2, 7'h15, 16'h0000);
      rd(2, 7'h15, v); chk("R1 rdata zero when deselected", v, 16'h0000);
      repeat (8) @(negedge clk);
      rd(0, 7'h15, v); chk("R1 deselected writes ignored", v, 16'h1200);
   endtask

   task automatic t_busy_ignore;
      logic [DW-1:0] v;
      int n;
      wr(0, 7'h16, 16'h0040);
      wr(0, 7'h16, 16'h00F0);
      wr(0, 7'h16, 16'h00FF);
      rd(0, 7'h16, v); chk("R12 busy read gives status", v, 16'h0000);
      wait_ready(0, n);
      rd(0, 7'h16, v); chk("R12 read-array ignored while busy", v, 16'h0080);
      wr(0, 7'h16, 16'h00FF);
      rd(0, 7'h16, v); chk("R3 second program word", v, 16'h00F0);
   endtask

   task automatic t_bad_seq;
      logic [DW-1:0] v;
      prog(0, 7'h0C, 16'h00FF);
      wr(0, 7'h0C, 16'h0020);
      wr(0, 7'h0C, 16'h00FF);
      rd(0, 7'h0C, v); chk("R5 bad erase sequence status", v, 16'h00B0);
      wr(0, 7'h0C, 16'h0050);
      rd(0, 7'h0C, v); chk("R9 clear status", v, 16'h0080);
      wr(0, 7'h0C, 16'h00FF);
      rd(0, 7'h0C, v); chk("R5 no erase on bad sequence", v, 16'h00FF);
   endtask

   task automatic t_vpp;
      logic [DW-1:0] v;
      vpp = 1'b0;
      wr(0, 7'h0C, 16'h0040);
      wr(0, 7'h0C, 16'h0000);
      rd(0, 7'h0C, v); chk("R6 program without supply", v, 16'h0098);
      wr(0, 7'h0C, 16'h0050);
      wr(0, 7'h0C, 16'h0020);
      wr(0, 7'h0C, 16'h00D0);
      rd(0, 7'h0C, v); chk("R6 erase without supply", v, 16'h00A8);
      wr(0, 7'h0C, 16'h0050);
      wr(0, 7'h0C, 16'h00FF);
      rd(0, 7'h0C, v); chk("R6 word untouched, read array works", v, 16'h00FF);
      vpp = 1'b1;
   endtask

   task automatic t_lock;
      logic [DW-1:0] v;
      int n;
      hv = 1'b0;
      wr(0, 7'h01, 16'h0040);
      wr(0, 7'h01, 16'h0000);
      rd(0, 7'h01, v); chk("R7 locked boot program", v, 16'h0090);
      wr(0, 7'h01, 16'h0050);
      wr(0, 7'h01, 16'h0020);
      wr(0, 7'h01, 16'h00D0);
      rd(0, 7'h01, v); chk("R7 locked boot erase", v, 16'h00A0);
      wr(0, 7'h01, 16'h0050);
      wr(0, 7'h01, 16'h00FF);
      rd(0, 7'h01, v); chk("R7 boot word unchanged", v, 16'hFFFF);
      hv = 1'b1;
      prog(0, 7'h01, 16'h5555);
      rd(0, 7'h01, v); chk("R7 unlocked status clean", v, 16'h0080);
      wr(0, 7'h01, 16'h00FF);
      rd(0, 7'h01, v); chk("R7 unlocked boot program", v, 16'h5555);
      hv = 1'b0;
   endtask

   task automatic t_ident;
      logic [DW-1:0] v;
      wr(0, 7'h00, 16'h0090);
      rd(0, 7'h00, v); chk("R11 maker code", v, 16'h005A);
      rd(0, 7'h01, v); chk("R11 bottom device code", v, 16'h00C4);
      wr(0, 7'h00, 16'h00FF);
   endtask

   task automatic t_erase;
      logic [DW-1:0] v;
      int n;
      prog(0, 7'h08, 16'h0F0F);
      prog(0, 7'h40, 16'h1111);
      erase(0, 7'h09, n);
      chk("R4 erase busy cycles", 16'(n), 16'(NE));
      wr(0, 7'h00, 16'h00FF);
      rd(0, 7'h08, v); chk("R4 parameter block erased", v, 16'hFFFF);
      rd(0, 7'h0C, v); chk("R4 neighbour block kept", v, 16'h00FF);
      erase(0, 7'h1C, n);
      wr(0, 7'h00, 16'h00FF);
      rd(0, 7'h15, v); chk("R4 main96 word erased", v, 16'hFFFF);
      rd(0, 7'h40, v); chk("R4 main128 kept", v, 16'h1111);
      rd(0, 7'h01, v); chk("R4 boot kept", v, 16'h5555);
   endtask

   task automatic t_suspend;
      logic [DW-1:0] v;
      int n;
      wr(0, 7'h40, 16'h0020);
      wr(0, 7'h40, 16'h00D0);
      repeat (3) @(negedge clk);
      wr(0, 7'h40, 16'h00B0);
      rd(0, 7'h40, v); chk("R10 suspended status", v, 16'h00C0);
      repeat (20) @(negedge clk);
      wr(0, 7'h40, 16'h00FF);
      rd(0, 7'h40, v); chk("R10 array readable while suspended", v, 16'h1111);
      wr(0, 7'h40, 16'h00D0);
      rd(0, 7'h40, v); chk("R10 busy after resume", v, 16'h0000);
      wait_ready(0, n);
      rd(0, 7'h40, v); chk("R10 status after completion", v, 16'h0080);
      wr(0, 7'h40, 16'h00FF);
      rd(0, 7'h40, v); chk("R10 erase completed after resume", v, 16'hFFFF);
   endtask

   task automatic t_reset_abort;
      logic [DW-1:0] v;
      prog(0, 7'h08, 16'h0000);
      wr(0, 7'h08, 16'h0020);
      wr(0, 7'h08, 16'h00D0);
      repeat (3) @(negedge clk);
      rstn = 1'b0;
      wr(0, 7'h0C, 16'h0040);
      wr(0, 7'h0C, 16'h0000);
      @(negedge clk);
      rstn = 1'b1;
      rd(0, 7'h08, v); chk("R2 erase abandoned by reset", v, 16'h0000);
      rd(0, 7'h0C, v); chk("R2 writes ignored under reset", v, 16'h00FF);
      wr(0, 7'h0C, 16'h0070);
      rd(0, 7'h0C, v); chk("R2 status ready after reset", v, 16'h0080);
   endtask

   task automatic t_topmap;
      logic [DW-1:0] v;
      int n;
      hv = 1'b0;
      wr(1, 7'h7C, 16'h0040);
      wr(1, 7'h7C, 16'h0000);
      rd(1, 7'h7C, v); chk("R8 top map boot at unit 31 locked", v, 16'h0090);
      wr(1, 7'h7C, 16'h0050);
      prog(1, 7'h00, 16'h0F0F);
      wr(1, 7'h00, 16'h00FF);
      rd(1, 7'h00, v); chk("R8 unit 0 unlocked in top map", v, 16'h0F0F);
      prog(1, 7'h74, 16'h1234);
      prog(1, 7'h70, 16'h4321);
      erase(1, 7'h75, n);
      wr(1, 7'h00, 16'h00FF);
      rd(1, 7'h74, v); chk("R8 mirrored parameter block erased", v, 16'hFFFF);
      rd(1, 7'h70, v); chk("R8 other parameter block kept", v, 16'h4321);
      wr(1, 7'h00, 16'h0090);
      rd(1, 7'h01, v); chk("R11 top device code", v, 16'h00C3);
      sel(0);
   endtask

   initial begin
      #(2_000_000);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_program();
      t_ce_ignored();
      t_busy_ignore();
      t_bad_seq();
      t_vpp();
      t_lock();
      t_ident();
      t_erase();
      t_suspend();
      t_reset_abort();
      t_topmap();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule